// File: doc/BRIEF.md
# Phase-Sampled External Clock Timer

This block is an 8-bit event counter whose count input is an asynchronous pin. The core runs from a fast oscillator clock that is divided into four repeating phases, Q1 through Q4, each one oscillator period long. The pin either feeds the sampling logic directly or first passes through a ripple divider clocked by the pin itself. The divider ratio is a power of two from 2 to 256.

The signal that reaches the core is registered on every oscillator edge. The registered value is examined only at the edges that close Q2 and Q4. A low-to-high change found at one of these points is held as a pending increment, and the timer applies it at a later Q4 closing edge. The delay from the pin to the count therefore depends on where the pin edge falls within the phase cycle. Software can load the count at any time. A load discards any pending increment and restarts the divider. Wrapping from the all-ones value to zero sets an overflow flag, which stays set until software clears it.

Top module: `phase_sampled_timer`

## Requirements
- R1: While `rst` is high at a clock edge, the count and the overflow flag go to zero. The phase sequence restarts so that the first cycle after reset is Q1, and then Q2, Q3 and Q4 follow in order, repeating.
- R2: Apart from loads, the count only changes at the clock edge that closes a Q4 cycle.
- R3: With the divider bypassed (`div_en`=0), the pin is registered on every clock edge. The registered value is compared against its previous examined value at the edges that close Q2 and Q4. A rise found at the Q2 closing edge is applied at the next Q4 closing edge. A rise found at the Q4 closing edge is applied at the following Q4 closing edge. The count thus changes 3 to 7 oscillator periods after the pin rises.
- R4: Each clean pin pulse (high for at least 2 periods, then low for at least 2 periods) adds exactly one to the count. Falling edges add nothing.
- R5: Two kinds of high level on the pin produce no increment: a level that spans no clock edge, and a level captured by only the single edge that closes Q2 or Q4.
- R6: With `div_en`=1 and ratio select `div_sel`=s, the count advances once per 2^(s+1) pin rising edges. After a clear, the first increment follows the 2^s-th rising edge. This holds for pin periods as short as 4 oscillator periods divided by the ratio.
- R7: A load (`tmr_wr`=1) puts `tmr_din` into the count at that edge, and it takes priority over a simultaneous increment. The load also discards any pending increment and clears the divider.
- R8: An increment from 0xFF to 0x00 sets `tmr_ovf`. The flag stays set through further counting until `ovf_clr` is high at a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock; four periods form one Q1..Q4 cycle |
| rst | input | 1 | Synchronous active-high reset |
| ext_pin | input | 1 | Asynchronous external count input |
| div_en | input | 1 | 1 selects the ripple divider, 0 passes the pin straight through |
| div_sel | input | 3 | Divider ratio select, ratio = 2^(div_sel+1) |
| tmr_wr | input | 1 | Load strobe for the count |
| tmr_din | input | 8 | Value to load |
| ovf_clr | input | 1 | Clears the overflow flag |
| tmr_count | output | 8 | Current count |
| tmr_ovf | output | 1 | Sticky wrap flag |

## Verification
A phase counter that is off by one moves every increment away from the Q4 closing edge. That shifts the measured pin-to-count delay, which the bench predicts to the exact clock edge for each starting phase. A stale or uncleared pending flag shows up as a count that steps after a load within one phase cycle. A divider that is not cleared shows up as an extra increment after a few more pin edges. A wrong divider tap changes how many edges pass before the first increment, and that appears at the port within one divided period.

// File: rtl/psamp_pkg.sv
`timescale 1ns/100ps
package psamp_pkg;

    typedef enum logic [1:0] {
        PH_Q1 = 2'd0,
        PH_Q2 = 2'd1,
        PH_Q3 = 2'd2,
        PH_Q4 = 2'd3
    } qphase_e;

    // strobes valid during the cycle; acted on at the edge closing it
    typedef struct packed {
        logic sample;
        logic commit;
    } phase_stb_t;

    function automatic phase_stb_t phase_strobes(qphase_e p);
        phase_stb_t s;
        s.sample = (p == PH_Q2) || (p == PH_Q4);
        s.commit = (p == PH_Q4);
        return s;
    endfunction

    function automatic qphase_e phase_next(qphase_e p);
        return qphase_e'(p + 2'd1);
    endfunction

endpackage

// File: rtl/psamp_phase_gen.sv
`timescale 1ns/100ps
module psamp_phase_gen
    import psamp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    output qphase_e    phase,
    output phase_stb_t stb
);
    always_ff @(posedge clk) begin
        if (rst) phase <= PH_Q1;
        else     phase <= phase_next(phase);
    end

    assign stb = phase_strobes(phase);
endmodule

// File: rtl/psamp_divider.sv
`timescale 1ns/100ps
module psamp_divider #(
    parameter int SEL_W = 3,
    localparam int DIV_W = 1 << SEL_W
) (
    input  logic             ext_pin,
    input  logic             clr,
    input  logic             div_en,
    input  logic [SEL_W-1:0] div_sel,
    output logic             src
);
    // ripple divider clocked by the pin, cleared from the core domain
    logic [DIV_W-1:0] stage;

    always_ff @(posedge ext_pin or posedge clr) begin
        if (clr) stage <= '0;
        else     stage <= stage + 1'b1;
    end

    assign src = div_en ? stage[div_sel] : ext_pin;
endmodule

// File: rtl/psamp_edge_sampler.sv
`timescale 1ns/100ps
module psamp_edge_sampler
    import psamp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       src,
    input  phase_stb_t stb,
    input  logic       flush,
    output logic       inc
);
    logic cap;   // registered every edge
    logic seen;  // value held at the last Q2/Q4 sample point
    logic pend;  // rise detected, waiting for Q4
    logic rise;

    assign rise = stb.sample && cap && !seen;
    assign inc  = stb.commit && pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap  <= 1'b0;
            seen <= 1'b0;
            pend <= 1'b0;
        end else begin
            cap <= src;
            if (stb.sample) seen <= cap;
            if (flush) pend <= 1'b0;
            else       pend <= (pend && !stb.commit) || rise;
        end
    end
endmodule

// File: rtl/psamp_count_reg.sv
`timescale 1ns/100ps
module psamp_count_reg #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [CNT_W-1:0] din,
    input  logic             inc,
    input  logic             ovf_clr,
    output logic [CNT_W-1:0] count,
    output logic             ovf
);
    logic wrap;
    assign wrap = inc && !wr && (count == {CNT_W{1'b1}});

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            ovf   <= 1'b0;
        end else begin
            if (wr)       count <= din;
            else if (inc) count <= count + 1'b1;
            if (wrap)         ovf <= 1'b1;
            else if (ovf_clr) ovf <= 1'b0;
        end
    end
endmodule

// File: rtl/phase_sampled_timer.sv
`timescale 1ns/100ps
module phase_sampled_timer
    import psamp_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ext_pin,
    input  logic             div_en,
    input  logic [SEL_W-1:0] div_sel,
    input  logic             tmr_wr,
    input  logic [CNT_W-1:0] tmr_din,
    input  logic             ovf_clr,
    output logic [CNT_W-1:0] tmr_count,
    output logic             tmr_ovf
);
    qphase_e    phase;
    phase_stb_t stb;
    logic       div_clr;
    logic       src;
    logic       inc;

    // one-cycle clear pulse for the pin-clocked divider
    always_ff @(posedge clk) div_clr <= rst | tmr_wr;

    psamp_phase_gen u_phase (
        .clk   (clk),
        .rst   (rst),
        .phase (phase),
        .stb   (stb)
    );

    psamp_divider #(.SEL_W(SEL_W)) u_div (
        .ext_pin (ext_pin),
        .clr     (div_clr),
        .div_en  (div_en),
        .div_sel (div_sel),
        .src     (src)
    );

    psamp_edge_sampler u_samp (
        .clk   (clk),
        .rst   (rst),
        .src   (src),
        .stb   (stb),
        .flush (tmr_wr),
        .inc   (inc)
    );

    psamp_count_reg #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .wr      (tmr_wr),
        .din     (tmr_din),
        .inc     (inc),
        .ovf_clr (ovf_clr),
        .count   (tmr_count),
        .ovf     (tmr_ovf)
    );
endmodule

// File: rtl/phase_sampled_timer_chk.sv
`timescale 1ns/100ps
module phase_sampled_timer_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [1:0]       phase,
    input logic             tmr_wr,
    input logic [CNT_W-1:0] tmr_din,
    input logic             ovf_clr,
    input logic [CNT_W-1:0] tmr_count,
    input logic             tmr_ovf
);
    assert_reset_state_R1: assert property (@(posedge clk)
        $past(rst) |-> (tmr_count == '0 && !tmr_ovf && phase == 2'd0));

    assert_q4_only_R2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(tmr_wr) && tmr_count != $past(tmr_count))
        |-> $past(phase) == 2'd3);

    assert_step_one_R4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(tmr_wr) && tmr_count != $past(tmr_count))
        |-> tmr_count == CNT_W'($past(tmr_count) + 1'b1));

    assert_load_wins_R7: assert property (@(posedge clk) disable iff (rst)
        ($past(tmr_wr) && !$past(rst)) |-> tmr_count == $past(tmr_din));

    assert_wrap_sets_R8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(tmr_wr) && $past(tmr_count) == {CNT_W{1'b1}}
         && tmr_count == '0) |-> tmr_ovf);

    assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(tmr_ovf) && !$past(ovf_clr)) |-> tmr_ovf);
endmodule

bind phase_sampled_timer phase_sampled_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .phase     (phase),
    .tmr_wr    (tmr_wr),
    .tmr_din   (tmr_din),
    .ovf_clr   (ovf_clr),
    .tmr_count (tmr_count),
    .tmr_ovf   (tmr_ovf)
);

// File: tb/tb_phase_sampled_timer.sv
`timescale 1ns/100ps
module tb_phase_sampled_timer;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ext_pin = 1'b0;
    logic       div_en = 1'b0;
    logic [2:0] div_sel = 3'd0;
    logic       tmr_wr = 1'b0;
    logic [7:0] tmr_din = 8'h00;
    logic       ovf_clr = 1'b0;
    logic [7:0] tmr_count;
    logic       tmr_ovf;

    phase_sampled_timer dut (
        .clk(clk), .rst(rst), .ext_pin(ext_pin), .div_en(div_en),
        .div_sel(div_sel), .tmr_wr(tmr_wr), .tmr_din(tmr_din),
        .ovf_clr(ovf_clr), .tmr_count(tmr_count), .tmr_ovf(tmr_ovf)
    );

    always #2.5 clk = ~clk;   // 200 MHz

    typedef struct {
        logic [7:0] v;
        realtime    t;     // expected edge time, 0 = any
        string      req;
    } exp_item_t;

    exp_item_t  sb[$];
    int         n_chk = 0;
    int         n_fail = 0;
    logic [7:0] model = 8'h00;
    logic [7:0] last = 8'h00;
    logic [1:0] ph_b = 2'd0;   // phase of the upcoming edge (R1 sequence)
    bit         done = 1'b0;

    always @(posedge clk) begin
        if (rst) ph_b <= 2'd0;
        else     ph_b <= ph_b + 2'd1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] v, input realtime t, input string req);
        exp_item_t it;
        it.v = v; it.t = t; it.req = req;
        sb.push_back(it);
    endtask

    // monitor: pops one expected item per observed count change
    always @(negedge clk) begin
        if (!rst && tmr_count != last) begin
            if (sb.size() == 0) begin
                chk(1'b0, "R2 unexpected change", int'(tmr_count), int'(last));
            end else begin
                exp_item_t it;
                it = sb.pop_front();
                chk(tmr_count == it.v, it.req, int'(tmr_count), int'(it.v));
                if (it.t != 0.0) begin
                    realtime dt;
                    dt = $realtime - 2.5 - it.t;
                    chk(dt < 0.05 && dt > -0.05, {it.req, " timing"},
                        int'(($realtime - 2.5) * 10.0), int'(it.t * 10.0));
                end
            end
            last = tmr_count;
        end
    end

    // edges from capture to commit, derived from R3
    function automatic int lat_edges(input int p);
        int n;
        int q;
        n = 1;
        q = (p + 1) % 4;
        if (q != 1 && q != 3) begin
            n++;
            q = (q + 1) % 4;
        end
        n += (q == 1) ? 2 : 4;
        return n;
    endfunction

    task automatic wait_phase(input int p);
        do @(negedge clk); while (int'(ph_b) != p);
    endtask

    task automatic load(input logic [7:0] v, input string req);
        @(negedge clk);
        tmr_wr = 1'b1; tmr_din = v;
        push(v, $realtime + 2.5, req);
        @(negedge clk);
        tmr_wr = 1'b0;
        model = v;
    endtask

    // clean pulse; push expected value first when it should count
    task automatic pulse(input bit counts, input string req);
        if (counts) begin
            model = model + 8'd1;
            push(model, 0.0, req);
        end
        ext_pin = 1'b1; #20;
        ext_pin = 1'b0; #20;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #1000000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        idle(4);
        rst = 1'b0;
        last = tmr_count;
        // R1: reset state
        chk(tmr_count == 8'h00, "R1 count", int'(tmr_count), 0);
        chk(tmr_ovf == 1'b0, "R1 ovf", int'(tmr_ovf), 0);

        // R3/R2: exact latency from each phase position, two offsets
        for (int p = 0; p < 4; p++) begin
            for (int k = 0; k < 2; k++) begin
                realtime tn;
                real d;
                d = (k == 0) ? 0.5 : 2.0;
                wait_phase(p);
                tn = $realtime;
                #(d);
                model = model + 8'd1;
                push(model, tn + 2.5 + 5.0 * lat_edges(p), "R3");
                ext_pin = 1'b1; #20;
                ext_pin = 1'b0; #20;
            end
        end
        idle(8);
        chk(tmr_count == 8'h08, "R4 total", int'(tmr_count), 8);

        // R5: pulse spanning no edge
        for (int p = 0; p < 4; p++) begin
            wait_phase(p);
            #0.5 ext_pin = 1'b1;
            #1.0 ext_pin = 1'b0;
        end
        // R5: pulse captured only by the edge closing Q2, then Q4
        wait_phase(1);
        #0.5 ext_pin = 1'b1;
        #4.0 ext_pin = 1'b0;
        wait_phase(3);
        #0.5 ext_pin = 1'b1;
        #4.0 ext_pin = 1'b0;
        idle(12);
        chk(tmr_count == model, "R5 no count", int'(tmr_count), int'(model));

        // R7: load discards a pending rise (rise detected at Q2 close)
        wait_phase(0);
        #0.5 ext_pin = 1'b1;
        wait_phase(2);
        tmr_wr = 1'b1; tmr_din = 8'h40;
        push(8'h40, $realtime + 2.5, "R7 load");
        @(negedge clk);
        tmr_wr = 1'b0;
        idle(8);
        ext_pin = 1'b0;
        idle(4);
        chk(tmr_count == 8'h40, "R7 pending flushed", int'(tmr_count), 8'h40);
        // R7: load on the commit edge wins
        wait_phase(0);
        #0.5 ext_pin = 1'b1;
        wait_phase(3);
        tmr_wr = 1'b1; tmr_din = 8'h50;
        push(8'h50, $realtime + 2.5, "R7 priority");
        @(negedge clk);
        tmr_wr = 1'b0;
        idle(8);
        ext_pin = 1'b0;
        idle(4);
        chk(tmr_count == 8'h50, "R7 load wins", int'(tmr_count), 8'h50);
        model = 8'h50;

        // R8: wrap and sticky flag
        load(8'hFE, "R8 load");
        idle(2);
        chk(tmr_ovf == 1'b0, "R8 before wrap", int'(tmr_ovf), 0);
        pulse(1'b1, "R8");
        pulse(1'b1, "R8");
        idle(2);
        chk(tmr_count == 8'h00 && tmr_ovf, "R8 wrap", int'({tmr_ovf, tmr_count}), 9'h100);
        pulse(1'b1, "R8");
        idle(2);
        chk(tmr_ovf == 1'b1, "R8 sticky", int'(tmr_ovf), 1);
        @(negedge clk) ovf_clr = 1'b1;
        @(negedge clk) ovf_clr = 1'b0;
        chk(tmr_ovf == 1'b0, "R8 clear", int'(tmr_ovf), 0);

        // R7: load clears the divider (ratio 4, first increment after 2 edges)
        div_en = 1'b1; div_sel = 3'd1;
        load(8'h30, "R7 load");
        idle(3);
        pulse(1'b0, "R7");
        load(8'h31, "R7 load");
        idle(3);
        pulse(1'b0, "R7");
        idle(4);
        chk(tmr_count == 8'h31, "R7 divider cleared", int'(tmr_count), 8'h31);
        pulse(1'b1, "R7 divider restart");
        idle(4);

        // R6: divided totals, slow pin
        for (int si = 0; si < 4; si++) begin
            int s;
            int half;
            s = (si == 3) ? 7 : si;
            half = 1 << s;
            div_sel = 3'(s);
            load(8'hA0 + 8'(si), "R6 load");
            idle(3);
            for (int i = 1; i <= 4 * half; i++) begin
                pulse((i % (2 * half)) == half, "R6");
            end
            idle(8);
            chk(tmr_count == 8'hA2 + 8'(si), "R6 total", int'(tmr_count), int'(8'hA2 + 8'(si)));
        end

        // R6: fast pin, 3 ns period with ratio 8
        div_sel = 3'd2;
        load(8'hC0, "R6 load");
        idle(3);
        for (int i = 1; i <= 8; i++) push(8'hC0 + 8'(i), 0.0, "R6 fast");
        for (int i = 0; i < 64; i++) begin
            ext_pin = 1'b1; #1.5;
            ext_pin = 1'b0; #1.5;
        end
        idle(20);
        chk(tmr_count == 8'hC8, "R6 fast total", int'(tmr_count), 8'hC8);
        chk(sb.size() == 0, "R6 scoreboard drained", sb.size(), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule